// File: doc/BRIEF.md
# Banked Page-Buffered Byte Store Controller

This block sits behind a two-wire serial slave engine. It owns a small byte store made of two equal banks, and only one bank can be seen at a time. The engine has already decoded the bus. It hands the controller one request per byte: a byte address, a write data byte, a read, or the end of the transfer. The controller answers each request one cycle later with an acknowledge flag and, for reads, a data byte. The controller keeps the address pointer. It gathers write data into a page buffer and commits that buffer as a timed write cycle after the transfer ends. While the write cycle runs, `busy` is high.

Writes can be refused in two ways. The first is a set of protection flags, one for each half of each bank. The second is a hardware write-protect input, which is captured once for each write transfer. Strobes from the engine select the visible bank and set or clear the flags. The engine answers bank and flag queries directly from the `active_bank` and `prot_flags` outputs.

Top module: `spd_bank_ctrl`

## Requirements
- R1: After reset, bank 0 is visible, the pointer is 0x00, all protection flags are clear, `busy` is low, and every byte of both banks reads 0xFF.
- R2: A request with `req_valid` high gets exactly one response. `rsp_valid` is high in the following cycle. A read request (`req_op`=2) returns the byte at the pointer in the visible bank with `rsp_ack`=1, and then increments the pointer. The pointer wraps from 0xFF to 0x00 inside the same bank. Responses that are not reads carry `rsp_data`=0x00.
- R3: An address request (`req_op`=0) loads the pointer from `req_byte`, is acknowledged, and opens a write transfer. A read that follows it is a selective read from that address.
- R4: A data request (`req_op`=1) stores its byte at the current buffer position. Bits 7:4 of the address pick the page and bits 3:0 give the starting position. The position then increments and wraps within the 16-byte page, so an extra byte overwrites an earlier one.
- R5: Buffered data reaches the store only after an end request (`req_op`=3) that closes a transfer in which at least one byte was accepted. Only the positions that were loaded change. A read request before the end request discards the buffer.
- R6: The write cycle starts in the cycle after the end request is accepted and holds `busy` high for exactly WR_CYCLES cycles. While `busy` is high, every request is answered with `rsp_ack`=0 and changes nothing.
- R7: The protection block index is 2*bank + address bit 7. A data byte aimed at a block whose flag is set gets `rsp_ack`=0, and the transfer then commits nothing.
- R8: The write-protect input is sampled when the address request is accepted. If it was high, every data byte of that transfer gets `rsp_ack`=0 and nothing is committed. Later changes of the input have no effect on that transfer.
- R9: The bank strobe selects the visible bank used by later reads and transfers. The set strobe raises one flag and the clear-all strobe lowers all flags. While `busy` is high, all of these strobes are ignored.
- R10: After a data byte is accepted, the pointer holds the page base plus the next buffer position, so a later read with no address continues after the last loaded byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Byte request strobe from the engine |
| req_op | input | 2 | 0 address, 1 write data, 2 read, 3 end of transfer |
| req_byte | input | 8 | Address or data byte |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| rsp_data | output | 8 | Read data |
| wp_pin | input | 1 | Hardware write-protect level |
| bank_sel_valid | input | 1 | Bank select strobe |
| bank_sel | input | 1 | Bank to make visible |
| prot_set_valid | input | 1 | Set one protection flag |
| prot_set_idx | input | 2 | Index of the flag to set |
| prot_clr_all | input | 1 | Clear every protection flag |
| active_bank | output | 1 | Visible bank |
| prot_flags | output | 4 | Protection flags, bit n guards block n |
| busy | output | 1 | Write cycle in progress |

## Verification
The assertions assume that the engine issues requests strictly one at a time, and that `req_op` always holds one of the four defined codes. They also assume that the write timer is only started while it is idle. The bench keeps to these assumptions: each request is a single-cycle pulse, and a new request goes out only after the response to the previous one has been seen. Some stimulus deliberately falls inside write cycles, such as reads and bank or flag strobes, to exercise the rule that requests and strobes are ignored while `busy` is high. Aside from those cases, the bench waits for `busy` to drop before it starts a new transfer.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WDATA = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef struct packed {
        logic              valid;
        logic              ack;
        logic [BYTE_W-1:0] data;
    } rsp_t;

    // protection block: two halves per bank, split on the top address bit
    function automatic int unsigned blk_index(int unsigned bank, logic hi_half);
        return bank * 2 + int'(hi_half);
    endfunction

endpackage

// File: rtl/spd_wr_timer.sv
module spd_wr_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start && cnt == '0) begin
            cnt <= CNT_W'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

    // R6: busy only rises because a write cycle was launched
    p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R6: the last cycle of a write cycle is followed by idle
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> !busy);

endmodule

// File: rtl/spd_prot_regs.sv
module spd_prot_regs #(
    parameter int NUM_BANKS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          busy,
    input  logic                          bank_sel_valid,
    input  logic [$clog2(NUM_BANKS)-1:0]   bank_sel,
    input  logic                          set_valid,
    input  logic [$clog2(NUM_BANKS*2)-1:0] set_idx,
    input  logic                          clr_all,
    output logic [$clog2(NUM_BANKS)-1:0]   active_bank,
    output logic [NUM_BANKS*2-1:0]         flags
);
    localparam int NUM_BLK = NUM_BANKS * 2;
    localparam int BLK_W   = $clog2(NUM_BLK);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_bank <= '0;
        end else if (!busy && bank_sel_valid) begin
            active_bank <= bank_sel;
        end
    end

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[g] <= 1'b0;
            end else if (!busy) begin
                if (clr_all) begin
                    flags[g] <= 1'b0;
                end else if (set_valid && set_idx == BLK_W'(g)) begin
                    flags[g] <= 1'b1;
                end
            end
        end
    end

    // R9: bank choice frozen during a write cycle
    p_bank_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(active_bank));

    // R9: protection flags frozen during a write cycle
    p_flags_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(flags));

endmodule

// File: rtl/spd_page_buf.sv
module spd_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear,
    input  logic [$clog2(PAGE_BYTES)-1:0] start_pos,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [$clog2(PAGE_BYTES)-1:0] pos,
    output logic [DATA_W-1:0]             data [PAGE_BYTES],
    output logic [PAGE_BYTES-1:0]         mask
);
    localparam int POS_W = $clog2(PAGE_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (clear) begin
            pos <= start_pos;
        end else if (wr_en) begin
            pos <= pos + 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                data[g] <= '0;
                mask[g] <= 1'b0;
            end else if (clear) begin
                mask[g] <= 1'b0;
            end else if (wr_en && pos == POS_W'(g)) begin
                data[g] <= wr_data;
                mask[g] <= 1'b1;
            end
        end
    end

    // R4: the load position wraps inside the page
    p_pos_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en && !clear && pos == POS_W'(PAGE_BYTES - 1) |=> pos == '0);

    // R4: a loaded slot is marked as holding data
    p_slot_marked_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en && !clear |=> mask != '0);

endmodule

// File: rtl/spd_bank_ctrl.sv
module spd_bank_ctrl
    import spd_pkg::*;
#(
    parameter int BANK_BYTES = 256,
    parameter int NUM_BANKS  = 2,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 20
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [1:0]                    req_op,
    input  logic [7:0]                    req_byte,
    output logic                          rsp_valid,
    output logic                          rsp_ack,
    output logic [7:0]                    rsp_data,
    input  logic                          wp_pin,
    input  logic                          bank_sel_valid,
    input  logic [$clog2(NUM_BANKS)-1:0]   bank_sel,
    input  logic                          prot_set_valid,
    input  logic [$clog2(NUM_BANKS*2)-1:0] prot_set_idx,
    input  logic                          prot_clr_all,
    output logic [$clog2(NUM_BANKS)-1:0]   active_bank,
    output logic [NUM_BANKS*2-1:0]         prot_flags,
    output logic                          busy
);
    localparam int PTR_W     = $clog2(BANK_BYTES);
    localparam int POS_W     = $clog2(PAGE_BYTES);
    localparam int PAGE_W    = PTR_W - POS_W;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int MEM_AW    = BANK_W + PTR_W;
    localparam int MEM_DEPTH = NUM_BANKS * BANK_BYTES;
    localparam int NUM_BLK   = NUM_BANKS * 2;
    localparam int BLK_W     = $clog2(NUM_BLK);

    op_e               op;
    rsp_t              rsp_q;
    logic [PTR_W-1:0]  ptr;
    logic [BANK_W-1:0] sess_bank;
    logic [PAGE_W-1:0] sess_page;
    logic              sess_open;
    logic              reject;
    logic              wp_lat;
    logic              accept;
    logic              blk_hit;
    logic              data_ok;
    logic              buf_clear;
    logic              buf_wr;
    logic              wr_start;
    logic              wr_done;
    logic [POS_W-1:0]  buf_pos;
    logic [BYTE_W-1:0] buf_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] buf_mask;
    logic [BLK_W-1:0]  blk;
    logic [MEM_AW-1:0] rd_addr;
    logic [BYTE_W-1:0] mem [MEM_DEPTH];

    assign op      = op_e'(req_op);
    assign accept  = req_valid && !busy;
    assign blk     = BLK_W'(blk_index(int'(sess_bank), sess_page[PAGE_W-1]));
    assign blk_hit = prot_flags[blk];
    assign data_ok = sess_open && !wp_lat && !blk_hit;
    assign rd_addr = {active_bank, ptr};

    assign buf_clear = accept && (op == OP_ADDR || op == OP_READ);
    assign buf_wr    = accept && op == OP_WDATA && data_ok;
    assign wr_start  = accept && op == OP_STOP && sess_open && !reject && (buf_mask != '0);

    spd_prot_regs #(.NUM_BANKS(NUM_BANKS)) u_prot (
        .clk           (clk),
        .rst           (rst),
        .busy          (busy),
        .bank_sel_valid(bank_sel_valid),
        .bank_sel      (bank_sel),
        .set_valid     (prot_set_valid),
        .set_idx       (prot_set_idx),
        .clr_all       (prot_clr_all),
        .active_bank   (active_bank),
        .flags         (prot_flags)
    );

    spd_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(BYTE_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .clear    (buf_clear),
        .start_pos(req_byte[POS_W-1:0]),
        .wr_en    (buf_wr),
        .wr_data  (req_byte),
        .pos      (buf_pos),
        .data     (buf_data),
        .mask     (buf_mask)
    );

    spd_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(wr_start),
        .busy (busy),
        .done (wr_done)
    );

    // request handling and pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q     <= '0;
            ptr       <= '0;
            sess_bank <= '0;
            sess_page <= '0;
            sess_open <= 1'b0;
            reject    <= 1'b0;
            wp_lat    <= 1'b0;
        end else begin
            rsp_q.valid <= req_valid;
            rsp_q.ack   <= 1'b0;
            rsp_q.data  <= '0;
            if (accept) begin
                unique case (op)
                    OP_ADDR: begin
                        rsp_q.ack <= 1'b1;
                        ptr       <= req_byte[PTR_W-1:0];
                        sess_bank <= active_bank;
                        sess_page <= req_byte[PTR_W-1:POS_W];
                        sess_open <= 1'b1;
                        reject    <= 1'b0;
                        wp_lat    <= wp_pin;
                    end
                    OP_WDATA: begin
                        if (data_ok) begin
                            rsp_q.ack <= 1'b1;
                            ptr       <= {sess_page, POS_W'(buf_pos + 1'b1)};
                        end else begin
                            reject <= 1'b1;
                        end
                    end
                    OP_READ: begin
                        rsp_q.ack  <= 1'b1;
                        rsp_q.data <= mem[rd_addr];
                        ptr        <= ptr + 1'b1;
                        sess_open  <= 1'b0;
                    end
                    OP_STOP: begin
                        rsp_q.ack <= 1'b1;
                        sess_open <= 1'b0;
                    end
                endcase
            end
        end
    end

    // byte store with page commit at the end of the write cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (wr_done) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (buf_mask[j]) begin
                    mem[{sess_bank, sess_page, POS_W'(j)}] <= buf_data[j];
                end
            end
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_ack   = rsp_q.ack;
    assign rsp_data  = rsp_q.data;

    // R2: each request is answered in the following cycle
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R6: requests during a write cycle are refused
    p_busy_nack_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && busy |=> rsp_valid && !rsp_ack);

    // R7: data aimed at a protected block is refused
    p_prot_nack_r7: assert property (@(posedge clk) disable iff (rst)
        accept && op == OP_WDATA && blk_hit |=> !rsp_ack);

    // R8: data after a high write-protect sample is refused
    p_wp_nack_r8: assert property (@(posedge clk) disable iff (rst)
        accept && op == OP_WDATA && wp_lat |=> !rsp_ack);

    // R5: a write cycle is never launched by a refused transfer
    p_no_commit_reject_r5: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> !reject && !wp_lat);

endmodule

// File: tb/sim_spd_bank_ctrl.sv
module sim_spd_bank_ctrl;
    localparam int WR = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_byte = 8'd0;
    logic       rsp_valid, rsp_ack;
    logic [7:0] rsp_data;
    logic       wp_pin = 1'b0;
    logic       bank_sel_valid = 1'b0;
    logic [0:0] bank_sel = 1'b0;
    logic       prot_set_valid = 1'b0;
    logic [1:0] prot_set_idx = 2'd0;
    logic       prot_clr_all = 1'b0;
    logic [0:0] active_bank;
    logic [3:0] prot_flags;
    logic       busy;

    spd_bank_ctrl #(.WR_CYCLES(WR)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_byte(req_byte),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data), .wp_pin(wp_pin),
        .bank_sel_valid(bank_sel_valid), .bank_sel(bank_sel), .prot_set_valid(prot_set_valid),
        .prot_set_idx(prot_set_idx), .prot_clr_all(prot_clr_all), .active_bank(active_bank),
        .prot_flags(prot_flags), .busy(busy)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    string tag = "R1";

    task automatic chk(string rq, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_mem [512];
    int m_bank, m_ptr, m_bcnt, m_sbank, m_spage, m_pos;
    bit m_flags [4];
    bit m_open, m_wp, m_rej;
    int q_pos [$];
    int q_dat [$];
    int e_v, e_ack, e_data;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 255;
            foreach (m_flags[i]) m_flags[i] = 0;
            m_bank = 0; m_ptr = 0; m_bcnt = 0; m_open = 0; m_rej = 0; m_wp = 0;
            m_sbank = 0; m_spage = 0; m_pos = 0;
            q_pos.delete(); q_dat.delete();
            e_v = 0; e_ack = 0; e_data = 0;
        end else begin
            automatic bit was_busy = (m_bcnt != 0);
            automatic bit commit   = (m_bcnt == 1);
            automatic bit start    = 0;
            e_v = int'(req_valid); e_ack = 0; e_data = 0;
            if (req_valid && !was_busy) begin
                case (req_op)
                    2'd0: begin
                        m_ptr = req_byte; m_sbank = m_bank; m_spage = req_byte / 16;
                        m_pos = req_byte % 16; m_wp = wp_pin; m_rej = 0; m_open = 1;
                        q_pos.delete(); q_dat.delete(); e_ack = 1;
                    end
                    2'd1: begin
                        automatic int b = m_sbank * 2 + m_spage / 8;
                        if (!m_open || m_wp || m_flags[b]) m_rej = 1;
                        else begin
                            q_pos.push_back(m_pos); q_dat.push_back(req_byte);
                            e_ack = 1; m_pos = (m_pos + 1) % 16; m_ptr = m_spage * 16 + m_pos;
                        end
                    end
                    2'd2: begin
                        e_ack = 1; e_data = m_mem[m_bank * 256 + m_ptr];
                        m_ptr = (m_ptr + 1) % 256; m_open = 0;
                        q_pos.delete(); q_dat.delete();
                    end
                    default: begin
                        e_ack = 1;
                        if (m_open && q_pos.size() > 0 && !m_rej) start = 1;
                        m_open = 0;
                    end
                endcase
            end
            if (!was_busy) begin
                if (bank_sel_valid) m_bank = int'(bank_sel);
                if (prot_clr_all) foreach (m_flags[i]) m_flags[i] = 0;
                else if (prot_set_valid) m_flags[prot_set_idx] = 1;
            end
            if (commit)
                foreach (q_pos[k]) m_mem[m_sbank * 256 + m_spage * 16 + q_pos[k]] = q_dat[k];
            if (m_bcnt > 0) m_bcnt--;
            if (start) m_bcnt = WR;
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            automatic int fl = 0;
            foreach (m_flags[i]) fl |= int'(m_flags[i]) << i;
            chk(tag, int'(rsp_valid), e_v, "rsp_valid");
            chk(tag, int'(rsp_ack), e_ack, "rsp_ack");
            chk(tag, int'(rsp_data), e_data, "rsp_data");
            chk(tag, int'(busy), int'(m_bcnt != 0), "busy");
            chk(tag, int'(active_bank), m_bank, "active_bank");
            chk(tag, int'(prot_flags), fl, "prot_flags");
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog (any R) actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic xfer(input int op, input int b, output int ack, output int dat);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_byte = 8'(b);
        @(negedge clk);
        req_valid = 1'b0;
        ack = int'(rsp_ack); dat = int'(rsp_data);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic rd1(input int a, output int dat);
        int ack, d;
        xfer(0, a, ack, d);
        xfer(2, 0, ack, dat);
        xfer(3, 0, ack, d);
    endtask

    task automatic wr_bytes(input int a, input int first, input int n);
        int ack, d;
        xfer(0, a, ack, d);
        for (int i = 0; i < n; i++) xfer(1, first + i, ack, d);
        xfer(3, 0, ack, d);
        wait_idle();
    endtask

    task automatic strobe_bank(input int b);
        @(negedge clk); bank_sel_valid = 1'b1; bank_sel = 1'(b);
        @(negedge clk); bank_sel_valid = 1'b0;
    endtask

    task automatic strobe_set(input int idx);
        @(negedge clk); prot_set_valid = 1'b1; prot_set_idx = 2'(idx);
        @(negedge clk); prot_set_valid = 1'b0;
    endtask

    task automatic strobe_clr();
        @(negedge clk); prot_clr_all = 1'b1;
        @(negedge clk); prot_clr_all = 1'b0;
    endtask

    initial begin
        int ack, d, n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        tag = "R1";
        chk("R1", int'(active_bank), 0, "bank after reset");
        chk("R1", int'(prot_flags), 0, "flags after reset");
        chk("R1", int'(busy), 0, "busy after reset");
        xfer(2, 0, ack, d); chk("R1", d, 8'hFF, "byte 0 after reset");
        xfer(2, 0, ack, d); chk("R1", d, 8'hFF, "byte 1 after reset");
        xfer(3, 0, ack, d);

        // R4 R10 page wrap with overflow
        tag = "R4";
        wr_bytes(8'h1E, 8'h40, 20);
        tag = "R10";
        xfer(2, 0, ack, d); chk("R10", d, 8'h44, "read continues after last load");
        xfer(3, 0, ack, d);
        tag = "R4";
        rd1(8'h10, d); chk("R4", d, 8'h52, "pos0 overwritten");
        rd1(8'h11, d); chk("R4", d, 8'h53, "pos1 overwritten");
        rd1(8'h1E, d); chk("R4", d, 8'h50, "pos14 second pass");
        rd1(8'h1F, d); chk("R4", d, 8'h51, "pos15 second pass");
        rd1(8'h20, d); chk("R4", d, 8'hFF, "next page untouched");

        // R5 partial page and discard
        tag = "R5";
        wr_bytes(8'h35, 8'hA1, 2);
        rd1(8'h34, d); chk("R5", d, 8'hFF, "unloaded byte kept");
        rd1(8'h35, d); chk("R5", d, 8'hA1, "loaded byte");
        rd1(8'h36, d); chk("R5", d, 8'hA2, "loaded byte");
        rd1(8'h37, d); chk("R5", d, 8'hFF, "unloaded byte kept");
        xfer(0, 8'h40, ack, d); xfer(1, 8'h11, ack, d); xfer(2, 0, ack, d); xfer(3, 0, ack, d);
        chk("R5", int'(busy), 0, "no cycle after discarded buffer");
        rd1(8'h40, d); chk("R5", d, 8'hFF, "discarded byte absent");

        // R6 busy length and refusal during a cycle; R9 strobes ignored
        tag = "R6";
        xfer(0, 8'h00, ack, d); xfer(1, 8'h5A, ack, d); xfer(3, 0, ack, d);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R6", n, WR, "busy cycles");
        xfer(0, 8'h60, ack, d); xfer(1, 8'h01, ack, d); xfer(3, 0, ack, d);
        xfer(2, 0, ack, d); chk("R6", ack, 0, "read during busy refused");
        tag = "R9";
        strobe_bank(1); chk("R9", int'(active_bank), 0, "bank strobe ignored while busy");
        strobe_set(0); chk("R9", int'(prot_flags), 0, "set ignored while busy");
        wait_idle();

        // R2 R3 selective read with bank wrap
        tag = "R2";
        xfer(0, 8'hFE, ack, d); chk("R3", ack, 1, "address acked");
        xfer(2, 0, ack, d); chk("R2", d, 8'hFF, "read FE");
        xfer(2, 0, ack, d); chk("R2", d, 8'hFF, "read FF");
        xfer(2, 0, ack, d); chk("R2", d, 8'h5A, "wrap to 00");
        xfer(3, 0, ack, d);

        // R9 bank selection
        tag = "R9";
        strobe_bank(1);
        rd1(8'h00, d); chk("R9", d, 8'hFF, "upper bank fresh");
        wr_bytes(8'h00, 8'h77, 1);
        rd1(8'h00, d); chk("R9", d, 8'h77, "upper bank written");
        strobe_bank(0);
        rd1(8'h00, d); chk("R9", d, 8'h5A, "lower bank kept");

        // R7 protection by block
        tag = "R7";
        strobe_set(1);
        xfer(0, 8'h80, ack, d); xfer(1, 8'h33, ack, d); chk("R7", ack, 0, "protected data refused");
        xfer(3, 0, ack, d); chk("R7", int'(busy), 0, "no cycle for protected");
        rd1(8'h80, d); chk("R7", d, 8'hFF, "protected byte unchanged");
        strobe_set(3); strobe_bank(1);
        xfer(0, 8'h90, ack, d); xfer(1, 8'h21, ack, d); chk("R7", ack, 0, "block 3 refused");
        xfer(3, 0, ack, d);
        xfer(0, 8'h10, ack, d); xfer(1, 8'h22, ack, d); chk("R7", ack, 1, "block 2 open");
        xfer(3, 0, ack, d); wait_idle();
        strobe_bank(0); strobe_clr();
        wr_bytes(8'h80, 8'h33, 1);
        rd1(8'h80, d); chk("R7", d, 8'h33, "written after clear");

        // R8 write-protect sampled at the address
        tag = "R8";
        wp_pin = 1'b1;
        xfer(0, 8'h50, ack, d);
        wp_pin = 1'b0;
        xfer(1, 8'h66, ack, d); chk("R8", ack, 0, "data refused after high sample");
        xfer(3, 0, ack, d);
        rd1(8'h50, d); chk("R8", d, 8'hFF, "byte unchanged");
        xfer(0, 8'h50, ack, d);
        wp_pin = 1'b1;
        xfer(1, 8'h66, ack, d); chk("R8", ack, 1, "late rise ignored");
        xfer(3, 0, ack, d);
        wp_pin = 1'b0;
        wait_idle();
        rd1(8'h50, d); chk("R8", d, 8'h66, "byte written");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule